// File: doc/BRIEF.md
# Predicate Register File with Compare

This block keeps a bank of one-bit predicate registers that stand in for a condition-flags register. A compare port evaluates a relation between two 64-bit operands and writes a complementary pair of predicates: the boolean outcome goes to the first destination index, and its inverse goes to the second. A read port looks up the qualifying predicate of an issuing instruction. It returns an execute-enable, and it gates that instruction's result writeback with it.

Predicate zero is tied true. It lets an instruction run unconditionally, and any compare write aimed at it is dropped. Each compare carries its own qualifying predicate.

- In the normal form, a false qualifier cancels the compare.
- In the unconditional form, a false qualifier forces both destinations to zero.

If a compare names the same destination twice, it is flagged as illegal and does not touch the bank.

Top module: `pred_file_cmp`

## Requirements
- R1: The bank holds 64 one-bit predicates. After reset, predicates 1 to 63 all read 0.
- R2: Predicate 0 always reads 1. A compare that names index 0 as a destination leaves it at 1, and the other destination is still written.
- R3: A legal compare with a true qualifier writes the relation result to the first destination `cmp_pd1` and its inverse to the second destination `cmp_pd2`.
- R4: The relation code `cmp_rel` uses bit 3 to select unsigned (1) or two's-complement signed (0) comparison. Bits 2:0 select the relation: 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge, each tested as A versus B. Codes 6 and 7 give a false result.
- R5: A normal compare (`cmp_uncond`=0) whose qualifying predicate `cmp_qp` reads 0 changes no predicate.
- R6: An unconditional compare (`cmp_uncond`=1) whose qualifying predicate reads 0 writes 0 to both destinations. With a true qualifier it behaves like a normal compare.
- R7: When `cmp_valid` is high and `cmp_pd1` equals `cmp_pd2`, `cmp_illegal` is high in the same cycle and no predicate changes. At all other times `cmp_illegal` is low.
- R8: `rd_en` equals the current value of predicate `rd_qp`. `wb_en` is high only when both `wb_req` and `rd_en` are high.
- R9: A predicate written by a compare in cycle t becomes visible to reads in cycle t+1. A read of it in cycle t still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_valid | input | 1 | Compare operation present this cycle |
| cmp_uncond | input | 1 | Selects the unconditional compare form |
| cmp_a | input | 64 | Compare operand A |
| cmp_b | input | 64 | Compare operand B |
| cmp_rel | input | 4 | Relation code (see R4) |
| cmp_qp | input | 6 | Qualifying predicate index of the compare |
| cmp_pd1 | input | 6 | Destination index receiving the result |
| cmp_pd2 | input | 6 | Destination index receiving the inverted result |
| cmp_illegal | output | 1 | Both destination indices are equal on a valid compare |
| rd_qp | input | 6 | Qualifying predicate index of the issuing instruction |
| wb_req | input | 1 | The issuing instruction wants to write back a result |
| rd_en | output | 1 | Execute-enable: value of predicate `rd_qp` |
| wb_en | output | 1 | Writeback permitted |

## Verification
A corrupted predicate does not show at the ports until a read selects it. Once it is read, it appears at once on `rd_en` and `wb_en` in that same cycle. If the same predicate qualifies a later compare, the error also spreads to other predicates. The reference model follows the whole bank and checks the read port on every cycle. Random compares use small index ranges, so a stale or stray write soon meets a read of the same index. Directed sequences read back each destination in the cycle after the write, which catches missing or premature updates within one cycle.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int REL_W = 4;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_LT = 3'd2,
    REL_LE = 3'd3,
    REL_GT = 3'd4,
    REL_GE = 3'd5
  } rel_kind_e;

  typedef struct packed {
    logic       is_unsigned;
    rel_kind_e  kind;
  } rel_code_t;
endpackage

// File: rtl/pred_rst_sync.sv
module pred_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pred_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [REL_W-1:0]  rel,
  output logic              outcome
);
  rel_code_t code;
  logic      is_eq;
  logic      less_s;
  logic      less_u;
  logic      less;

  assign code   = rel_code_t'(rel);
  assign is_eq  = (opa == opb);
  assign less_s = ($signed(opa) < $signed(opb));
  assign less_u = (opa < opb);
  assign less   = code.is_unsigned ? less_u : less_s;

  always_comb begin
    outcome = 1'b0;
    case (code.kind)
      REL_EQ:  outcome = is_eq;
      REL_NE:  outcome = !is_eq;
      REL_LT:  outcome = less;
      REL_LE:  outcome = less | is_eq;
      REL_GT:  outcome = !(less | is_eq);
      REL_GE:  outcome = !less;
      default: outcome = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_regs.sv
module pred_regs #(
  parameter int NUM_PRED = 64,
  parameter int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx_a,
  input  logic                wr_val_a,
  input  logic [IDX_W-1:0]    wr_idx_b,
  input  logic                wr_val_b,
  output logic [NUM_PRED-1:0] pred_q
);
  logic [NUM_PRED-1:1] bank_q;
  logic [NUM_PRED-1:1] bank_d;

  for (genvar i = 1; i < NUM_PRED; i++) begin : g_bit
    logic hit_a;
    logic hit_b;
    assign hit_a     = wr_en && (wr_idx_a == IDX_W'(i));
    assign hit_b     = wr_en && (wr_idx_b == IDX_W'(i));
    assign bank_d[i] = hit_b ? wr_val_b : (hit_a ? wr_val_a : bank_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_en) begin
      bank_q <= bank_d;
    end
  end

  assign pred_q = {bank_q, 1'b1};
endmodule

// File: rtl/pred_file_cmp.sv
module pred_file_cmp
  import pred_pkg::*;
#(
  parameter int NUM_PRED = 64,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              cmp_uncond,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [REL_W-1:0]  cmp_rel,
  input  logic [IDX_W-1:0]  cmp_qp,
  input  logic [IDX_W-1:0]  cmp_pd1,
  input  logic [IDX_W-1:0]  cmp_pd2,
  output logic              cmp_illegal,
  input  logic [IDX_W-1:0]  rd_qp,
  input  logic              wb_req,
  output logic              rd_en,
  output logic              wb_en
);
  logic                rst_sync_n;
  logic [NUM_PRED-1:0] pred_q;
  logic                outcome;
  logic                qual;
  logic                wr_go;
  logic                val_a;
  logic                val_b;

  pred_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pred_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
    .opa     (cmp_a),
    .opb     (cmp_b),
    .rel     (cmp_rel),
    .outcome (outcome)
  );

  assign qual        = pred_q[cmp_qp];
  assign cmp_illegal = cmp_valid && (cmp_pd1 == cmp_pd2);
  assign wr_go       = cmp_valid && !cmp_illegal && (qual || cmp_uncond);
  assign val_a       = qual & outcome;
  assign val_b       = qual & ~outcome;

  pred_regs #(.NUM_PRED(NUM_PRED), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_go),
    .wr_idx_a (cmp_pd1),
    .wr_val_a (val_a),
    .wr_idx_b (cmp_pd2),
    .wr_val_b (val_b),
    .pred_q   (pred_q)
  );

  assign rd_en = pred_q[rd_qp];
  assign wb_en = wb_req & rd_en;
endmodule

// File: rtl/pred_file_cmp_chk.sv
module pred_file_cmp_chk #(
  parameter int NUM_PRED = 64,
  parameter int IDX_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmp_valid,
  input logic                cmp_uncond,
  input logic [IDX_W-1:0]    cmp_qp,
  input logic [IDX_W-1:0]    cmp_pd1,
  input logic [IDX_W-1:0]    cmp_pd2,
  input logic                cmp_illegal,
  input logic [NUM_PRED-1:0] pred_q
);
  assert_illegal_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_illegal |=> (pred_q == $past(pred_q)));

  assert_false_qual_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_uncond && !pred_q[cmp_qp]) |=> (pred_q == $past(pred_q)));

  assert_pair_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_illegal && pred_q[cmp_qp] && cmp_pd1 != '0 && cmp_pd2 != '0)
    |=> (pred_q[$past(cmp_pd1)] != pred_q[$past(cmp_pd2)]));

  assert_uncond_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_uncond && !cmp_illegal && !pred_q[cmp_qp])
    |=> (!pred_q[$past(cmp_pd1)] || $past(cmp_pd1) == '0)
        && (!pred_q[$past(cmp_pd2)] || $past(cmp_pd2) == '0));

  assert_p0_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (cmp_pd1 == '0 || cmp_pd2 == '0)) |=> pred_q[0]);
endmodule

bind pred_file_cmp pred_file_cmp_chk #(.NUM_PRED(NUM_PRED), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cmp_valid   (cmp_valid),
  .cmp_uncond  (cmp_uncond),
  .cmp_qp      (cmp_qp),
  .cmp_pd1     (cmp_pd1),
  .cmp_pd2     (cmp_pd2),
  .cmp_illegal (cmp_illegal),
  .pred_q      (pred_q)
);

// File: tb/pred_file_cmp_test.sv
`timescale 1ns/100ps
module pred_file_cmp_test;
  logic        clk;
  logic        rst_n;
  logic        cmp_valid;
  logic        cmp_uncond;
  logic [63:0] cmp_a;
  logic [63:0] cmp_b;
  logic [3:0]  cmp_rel;
  logic [5:0]  cmp_qp;
  logic [5:0]  cmp_pd1;
  logic [5:0]  cmp_pd2;
  logic        cmp_illegal;
  logic [5:0]  rd_qp;
  logic        wb_req;
  logic        rd_en;
  logic        wb_en;

  int vectors = 0;
  int miscompares = 0;
  bit model [64];

  pred_file_cmp uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_uncond(cmp_uncond),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_rel(cmp_rel), .cmp_qp(cmp_qp),
    .cmp_pd1(cmp_pd1), .cmp_pd2(cmp_pd2), .cmp_illegal(cmp_illegal),
    .rd_qp(rd_qp), .wb_req(wb_req), .rd_en(rd_en), .wb_en(wb_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit ref_rel(logic [63:0] a, logic [63:0] b, logic [3:0] rel);
    longint sa = longint'(a);
    longint sb = longint'(b);
    bit lt = rel[3] ? (a < b) : (sa < sb);
    bit eq = (a == b);
    case (rel[2:0])
      3'd0: return eq;
      3'd1: return !eq;
      3'd2: return lt;
      3'd3: return lt || eq;
      3'd4: return !lt && !eq;
      3'd5: return !lt;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic v, logic unc, logic [63:0] a, logic [63:0] b,
                      logic [3:0] rel, logic [5:0] qp, logic [5:0] d1,
                      logic [5:0] d2, logic [5:0] rq, logic wr, string tag);
    bit ill, q, r, go;
    cmp_valid = v; cmp_uncond = unc; cmp_a = a; cmp_b = b; cmp_rel = rel;
    cmp_qp = qp; cmp_pd1 = d1; cmp_pd2 = d2; rd_qp = rq; wb_req = wr;
    #1;
    check(tag, rd_en, model[rq]);
    check({tag, "/R8"}, wb_en, wr & model[rq]);
    ill = v && (d1 == d2);
    check({tag, "/R7"}, cmp_illegal, ill);
    q  = model[qp];
    r  = ref_rel(a, b, rel);
    go = v && !ill && (q || unc);
    @(posedge clk);
    if (go) begin
      if (d1 != 0) model[d1] = q & r;
      if (d2 != 0) model[d2] = q & !r;
    end
    @(negedge clk);
  endtask

  task automatic probe(logic [5:0] idx, string tag);
    step(1'b0, 1'b0, 64'd0, 64'd0, 4'd0, 6'd0, 6'd1, 6'd2, idx, 1'b1, tag);
  endtask

  task automatic cmpw(logic unc, logic [63:0] a, logic [63:0] b, logic [3:0] rel,
                      logic [5:0] qp, logic [5:0] d1, logic [5:0] d2, string tag);
    step(1'b1, unc, a, b, rel, qp, d1, d2, 6'd0, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] ops [4];
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    ops[0] = 64'hFFFF_FFFF_FFFF_FFFF; ops[1] = 64'd1;
    ops[2] = 64'h8000_0000_0000_0000; ops[3] = 64'd0;
    rst_n = 1'b0; cmp_valid = 1'b0; cmp_uncond = 1'b0; cmp_a = '0; cmp_b = '0;
    cmp_rel = '0; cmp_qp = '0; cmp_pd1 = '0; cmp_pd2 = '0; rd_qp = '0; wb_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2: reset state
    for (int i = 0; i < 64; i++) probe(6'(i), (i == 0) ? "R2" : "R1");

    // R3: result and complement
    cmpw(1'b0, 64'd5, 64'd5, 4'd0, 6'd0, 6'd3, 6'd4, "R3");
    probe(6'd3, "R3"); probe(6'd4, "R3");

    // R9: same-cycle read sees old value, next cycle sees new
    step(1'b1, 1'b0, 64'd7, 64'd7, 4'd0, 6'd0, 6'd10, 6'd11, 6'd10, 1'b1, "R9");
    probe(6'd10, "R9");

    // R4: every relation code over signed/unsigned corner pairs
    for (int rel = 0; rel < 16; rel++)
      for (int p = 0; p < 4; p++) begin
        cmpw(1'b0, ops[p], ops[(p + 1) % 4], 4'(rel), 6'd0, 6'd20, 6'd21, "R4");
        probe(6'd20, "R4"); probe(6'd21, "R4");
        cmpw(1'b0, ops[p], ops[p], 4'(rel), 6'd0, 6'd20, 6'd21, "R4");
        probe(6'd20, "R4");
      end

    // R2: writes to p0 ignored, partner still written
    cmpw(1'b0, 64'd1, 64'd2, 4'd0, 6'd0, 6'd0, 6'd5, "R2");
    probe(6'd0, "R2"); probe(6'd5, "R2");
    cmpw(1'b0, 64'd1, 64'd1, 4'd0, 6'd0, 6'd6, 6'd0, "R2");
    probe(6'd0, "R2"); probe(6'd6, "R2");

    // R5: false qualifier cancels normal compare
    cmpw(1'b0, 64'd1, 64'd2, 4'd0, 6'd0, 6'd7, 6'd8, "R5");
    cmpw(1'b0, 64'd9, 64'd9, 4'd0, 6'd7, 6'd4, 6'd3, "R5");
    probe(6'd3, "R5"); probe(6'd4, "R5");

    // R6: unconditional with false qualifier clears both
    cmpw(1'b1, 64'd9, 64'd9, 4'd0, 6'd7, 6'd5, 6'd8, "R6");
    probe(6'd5, "R6"); probe(6'd8, "R6");
    cmpw(1'b1, 64'd9, 64'd9, 4'd0, 6'd0, 6'd5, 6'd8, "R6");
    probe(6'd5, "R6"); probe(6'd8, "R6");

    // R7: equal destinations flagged, no change
    cmpw(1'b0, 64'd1, 64'd1, 4'd0, 6'd0, 6'd5, 6'd5, "R7");
    probe(6'd5, "R7");
    cmpw(1'b1, 64'd1, 64'd1, 4'd0, 6'd8, 6'd8, 6'd8, "R7");
    probe(6'd8, "R7");

    // R8: random mix of compares and qualified reads
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, b,
           4'($urandom_range(0, 15)), 6'($urandom_range(0, 7)),
           6'($urandom_range(0, 7)), 6'($urandom_range(0, 7)),
           6'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule